// File: doc/BRIEF.md
# Interrupt Priority Daisy-Chain Unit

This block is the interrupt side of a peripheral on an 8-bit bus with a multiplexed opcode-fetch strobe (M1), an I/O request strobe and a read strobe. An internal cause strobe makes an interrupt pending. The unit then requests service with an active-low, open-drain style request, modelled as a drive-low enable. It raises the request only while the processor owns the bus and no higher-priority device holds the chain.

Priority between devices is set by a daisy chain. The priority-in line (IEI) comes from the next higher device and the priority-out line (IEO) feeds the next lower device. When the processor starts a machine cycle, a device with a pending request claims the chain by dropping IEO. If that cycle turns out to be an interrupt acknowledge (M1 and IORQ low together), the claiming device drives its programmable vector onto the data bus and enters the in-service state. It stays in service, holding IEO low, until it sees the two-byte return-from-interrupt opcode on two consecutive opcode fetches while its IEI is high.

Top module: `irq_chain_unit`

## Requirements
- R1: After reset the request drive is off, the vector drive enable is off, and IEO equals IEI.
- R2: One clock after a cycle with `cause_i` high, the request drive `int_drv_o` is high, provided IEI is high and `cpu_master_i` is high.
- R3: The request drive is low whenever `cpu_master_i` is low or IEI is low. The pending state is kept, so the request returns once both are high again.
- R4: During an acknowledge (`m1_n_i` and `iorq_n_i` both low) that follows an M1 fall taken while a request was pending, `vec_oe_o` is high and `vec_o` equals `vec_base_i`.
- R5: One clock after an acknowledge is accepted, the request drive is low and IEO stays low after M1 returns high (in-service).
- R6: One clock after M1 falls while a request is pending and IEI is high, IEO is low, before any acknowledge.
- R7: A fetch of 0xED followed by a fetch of 0x4D clears the in-service state, provided IEI is high, so IEO goes high again. A fetch is M1 and RD low with IORQ high, and the byte is taken on the first clock of the fetch.
- R8: A 0xED fetch followed by any other opcode leaves the in-service state unchanged.
- R9: A 0xED, 0x4D pair fetched while IEI is low leaves the in-service state unchanged.
- R10: IEO is low whenever IEI is low.
- R11: An acknowledge with nothing claimed leaves `vec_oe_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cause_i | input | 1 | Interrupt cause strobe |
| m1_n_i | input | 1 | Opcode-fetch / acknowledge strobe, active low |
| iorq_n_i | input | 1 | I/O request strobe, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| data_i | input | 8 | Data bus as seen by the unit |
| vec_base_i | input | 8 | Programmed interrupt vector |
| cpu_master_i | input | 1 | High while the processor owns the bus |
| iei_i | input | 1 | Priority in |
| int_drv_o | output | 1 | Drive the request line low |
| ieo_o | output | 1 | Priority out |
| vec_oe_o | output | 1 | Drive vector onto the data bus |
| vec_o | output | 8 | Vector value |

## Verification
The hardest states to reach from the ports are the in-service state combined with a return-from-interrupt sequence that must be ignored. The stimulus first completes a full pend, claim and acknowledge cycle. From there it issues a broken 0xED pair, and then a correct pair while IEI is held low. In each case IEO is read after IEI is high again to show that service was not ended. Only then does it send the correct pair with IEI high and check that IEO recovers.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam logic [BYTE_W-1:0] RETI_PREFIX = 8'hED;
   localparam logic [BYTE_W-1:0] RETI_SUFFIX = 8'h4D;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode (
   input  logic clk,
   input  logic rst_n,
   input  logic m1_n_i,
   input  logic iorq_n_i,
   input  logic rd_n_i,
   output logic m1_fall_o,
   output logic m1_idle_o,
   output logic ack_act_o,
   output logic fetch_start_o
);
   logic m1_q;
   logic fetch_q;
   logic fetch_now;

   assign fetch_now     = !m1_n_i && !rd_n_i && iorq_n_i;
   assign m1_fall_o     = !m1_n_i && m1_q;
   assign m1_idle_o     = m1_n_i;
   assign ack_act_o     = !m1_n_i && !iorq_n_i;
   assign fetch_start_o = fetch_now && !fetch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m1_q    <= 1'b1;
         fetch_q <= 1'b0;
      end else begin
         m1_q    <= m1_n_i;
         fetch_q <= fetch_now;
      end
   end
endmodule

// File: rtl/irq_reti_watch.sv
module irq_reti_watch #(
   parameter int unsigned DATA_W = 8,
   parameter logic [DATA_W-1:0] PREFIX = 8'hED,
   parameter logic [DATA_W-1:0] SUFFIX = 8'h4D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_start_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              reti_hit_o
);
   logic saw_prefix_q;

   assign reti_hit_o = fetch_start_i && saw_prefix_q && (data_i == SUFFIX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) saw_prefix_q <= 1'b0;
      else if (fetch_start_i) saw_prefix_q <= (data_i == PREFIX);
   end
endmodule

// File: rtl/irq_svc_ctl.sv
module irq_svc_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic cause_i,
   input  logic m1_fall_i,
   input  logic m1_idle_i,
   input  logic ack_act_i,
   input  logic reti_hit_i,
   input  logic iei_i,
   input  logic cpu_master_i,
   output logic int_drv_o,
   output logic ieo_o,
   output logic vec_oe_o,
   output logic claim_o
);
   logic pend_q, claim_q, isr_q;
   logic accept;

   assign accept    = ack_act_i && claim_q;
   assign int_drv_o = pend_q && !claim_q && iei_i && cpu_master_i;
   assign ieo_o     = iei_i && !isr_q && !claim_q;
   assign vec_oe_o  = accept;
   assign claim_o   = claim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         claim_q <= 1'b0;
         isr_q   <= 1'b0;
      end else begin
         pend_q <= (pend_q && !accept) || cause_i;
         if (m1_idle_i) claim_q <= 1'b0;
         else if (m1_fall_i) claim_q <= pend_q && iei_i;
         if (accept) isr_q <= 1'b1;
         else if (reti_hit_i && iei_i) isr_q <= 1'b0;
      end
   end

   p_isr_from_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(isr_q) |-> $past(ack_act_i && claim_q));
   p_vec_before_svc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(isr_q) |-> $past(vec_oe_o));
   p_reti_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(isr_q) |-> $past(reti_hit_i && iei_i));
   p_claim_needs_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(claim_q) |-> $past(pend_q && iei_i && m1_fall_i));
endmodule

// File: rtl/irq_chain_unit.sv
module irq_chain_unit #(
   parameter int unsigned DATA_W = irq_chain_pkg::BYTE_W,
   parameter bit          VEC_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cause_i,
   input  logic              m1_n_i,
   input  logic              iorq_n_i,
   input  logic              rd_n_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [DATA_W-1:0] vec_base_i,
   input  logic              cpu_master_i,
   input  logic              iei_i,
   output logic              int_drv_o,
   output logic              ieo_o,
   output logic              vec_oe_o,
   output logic [DATA_W-1:0] vec_o
);
   generate
      if (DATA_W != irq_chain_pkg::BYTE_W) begin : g_bad_width
         $error("irq_chain_unit: DATA_W must be 8 to decode opcodes");
      end
   endgenerate

   logic m1_fall, m1_idle, ack_act, fetch_start, reti_hit, claim;

   irq_bus_decode u_dec (
      .clk(clk), .rst_n(rst_n), .m1_n_i(m1_n_i), .iorq_n_i(iorq_n_i),
      .rd_n_i(rd_n_i), .m1_fall_o(m1_fall), .m1_idle_o(m1_idle),
      .ack_act_o(ack_act), .fetch_start_o(fetch_start)
   );

   irq_reti_watch #(
      .DATA_W(DATA_W),
      .PREFIX(irq_chain_pkg::RETI_PREFIX),
      .SUFFIX(irq_chain_pkg::RETI_SUFFIX)
   ) u_reti (
      .clk(clk), .rst_n(rst_n), .fetch_start_i(fetch_start),
      .data_i(data_i), .reti_hit_o(reti_hit)
   );

   irq_svc_ctl u_svc (
      .clk(clk), .rst_n(rst_n), .cause_i(cause_i), .m1_fall_i(m1_fall),
      .m1_idle_i(m1_idle), .ack_act_i(ack_act), .reti_hit_i(reti_hit),
      .iei_i(iei_i), .cpu_master_i(cpu_master_i), .int_drv_o(int_drv_o),
      .ieo_o(ieo_o), .vec_oe_o(vec_oe_o), .claim_o(claim)
   );

   generate
      if (VEC_REGISTERED) begin : g_vec_reg
         logic [DATA_W-1:0] vec_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) vec_q <= '0;
            else if (!claim) vec_q <= vec_base_i;
         end
         assign vec_o = vec_q;
      end else begin : g_vec_direct
         assign vec_o = vec_base_i;
      end
   endgenerate

   p_ieo_follows_iei_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !iei_i |-> !ieo_o);
   p_vec_only_in_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
      vec_oe_o |-> (!m1_n_i && !iorq_n_i));
endmodule

// File: tb/irq_chain_unit_tb.sv
module irq_chain_unit_tb_top;
   localparam time CLK_PERIOD = 10ns;
   localparam int  WATCHDOG   = 5000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cause = 1'b0, m1_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1;
   logic [7:0] data = 8'h00, vbase = 8'hA6;
   logic master = 1'b1, iei = 1'b1;
   logic int_drv, ieo, vec_oe;
   logic [7:0] vec;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_chain_unit dut_i (
      .clk(clk), .rst_n(rst_n), .cause_i(cause), .m1_n_i(m1_n),
      .iorq_n_i(iorq_n), .rd_n_i(rd_n), .data_i(data), .vec_base_i(vbase),
      .cpu_master_i(master), .iei_i(iei), .int_drv_o(int_drv), .ieo_o(ieo),
      .vec_oe_o(vec_oe), .vec_o(vec)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic fetch(input logic [7:0] op);
      m1_n = 1'b0; rd_n = 1'b0; data = op;
      tick(); tick();
      m1_n = 1'b1; rd_n = 1'b1;
      tick();
   endtask

   task automatic t_reset();
      chk("R1 int_drv", {7'd0, int_drv}, 8'd0);
      chk("R1 vec_oe", {7'd0, vec_oe}, 8'd0);
      chk("R1 ieo", {7'd0, ieo}, 8'd1);
   endtask

   task automatic t_request();
      cause = 1'b1; tick(); cause = 1'b0;
      chk("R2 request", {7'd0, int_drv}, 8'd1);
      master = 1'b0; #1;
      chk("R3 no master", {7'd0, int_drv}, 8'd0);
      master = 1'b1; iei = 1'b0; #1;
      chk("R3 iei low", {7'd0, int_drv}, 8'd0);
      chk("R10 ieo low", {7'd0, ieo}, 8'd0);
      iei = 1'b1; tick();
      chk("R3 request kept", {7'd0, int_drv}, 8'd1);
   endtask

   task automatic t_ack();
      m1_n = 1'b0; tick();
      chk("R6 ieo after m1 fall", {7'd0, ieo}, 8'd0);
      iorq_n = 1'b0; #1;
      chk("R4 vec_oe", {7'd0, vec_oe}, 8'd1);
      chk("R4 vec", vec, 8'hA6);
      tick();
      chk("R5 request withdrawn", {7'd0, int_drv}, 8'd0);
      m1_n = 1'b1; iorq_n = 1'b1; tick(); tick();
      chk("R5 ieo in service", {7'd0, ieo}, 8'd0);
      chk("R5 vec_oe off", {7'd0, vec_oe}, 8'd0);
   endtask

   task automatic t_reti_broken();
      fetch(8'hED); fetch(8'h00);
      chk("R8 still in service", {7'd0, ieo}, 8'd0);
   endtask

   task automatic t_reti_low_iei();
      iei = 1'b0;
      fetch(8'hED); fetch(8'h4D);
      iei = 1'b1; tick();
      chk("R9 still in service", {7'd0, ieo}, 8'd0);
   endtask

   task automatic t_reti_good();
      fetch(8'hED); fetch(8'h4D);
      chk("R7 service ended", {7'd0, ieo}, 8'd1);
   endtask

   task automatic t_no_claim();
      m1_n = 1'b0; tick(); iorq_n = 1'b0; #1;
      chk("R11 no vec_oe", {7'd0, vec_oe}, 8'd0);
      tick();
      chk("R11 ieo high", {7'd0, ieo}, 8'd1);
      m1_n = 1'b1; iorq_n = 1'b1; tick();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_request();
      t_ack();
      t_reti_broken();
      t_reti_low_iei();
      t_reti_good();
      t_no_claim();
      finish_run();
   end
endmodule